// File: doc/BRIEF.md
# Gated Frequency Counter with Decade Timebase

This block measures the rate of an unknown pulse train. It counts that train's rising edges during a sampling window whose length is set by a reference tick. A chain of divide-by-ten prescalers slows the reference tick, and a range input picks one of the prescaler outputs as the interval rate. Two toggle stages then run a repeating four-interval sequence:

- The counter is cleared.
- One full interval passes with the window shut.
- The window stays open for exactly one interval.
- The frozen count is held for two more intervals.

The result is a reading of three BCD digits. Each reading equals the number of input edges seen in one interval. The displayed digits and an overflow flag are loaded once per sequence, just before the next clear, so they never show a count that is still running. The unknown input is asynchronous. It passes through a two-stage synchroniser before edge detection. Driving the segments of a display is left to the logic outside this block.

Top module: `gated_rate_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, and from the following edge on, `bcd_out` reads 000 and `overflow` reads 0.
- R2: With `range_sel` = k, the interval T lasts 10^k reference ticks. Value 0 uses the reference tick directly. Values above NUM_DECADES-1 select the slowest tap.
- R3: After the input has been steady for a full sequence, the reading equals the number of input rising edges per interval T, within plus or minus one count.
- R4: Edges outside the open window are ignored. Only one interval out of every four is counted, so a steady input never shows about twice its per-interval edge count.
- R5: The sequence repeats every 4T. The counter clears once per sequence, and the displayed result changes exactly 4T after the previous load.
- R6: A count that passes 999 sets `overflow`. The digits wrap modulo 1000 and the flag stays set until the next clear. A later reading below 1000 shows `overflow` = 0.
- R7: `bcd_out` and `overflow` change at most once per sequence, and only at the load point.
- R8: `bcd_out[3:0]` holds units, `[7:4]` holds tens and `[11:8]` holds hundreds. Each digit is in the range 0 to 9.
- R9: Only rising edges of `sig_in` are counted. An input held high gives a reading of 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle pulse at the reference rate |
| sig_in | input | 1 | Unknown pulse train, asynchronous |
| range_sel | input | 3 | Decade tap selecting the interval |
| bcd_out | output | 12 | Held reading, three BCD digits |
| overflow | output | 1 | Held flag: the count passed 999 |

## Verification
The hardest situation to reach from the ports is the timing of the sequence itself. The load point is not visible, and the window phase is hidden behind the prescalers. The bench reaches it in two steps. It first lets a zero reading settle, then switches the input on and waits for the first nonzero load. At that moment it silences the input and measures the cycles until the display returns to zero, which must be exactly four intervals. Overflow needs more than 999 edges in one window, so it is reached only on the slowest tap with a fast input.

// File: rtl/grm_pkg.sv
// Shared types for the gated rate meter.
// Assumes digits are plain 4-bit BCD values.
package grm_pkg;
    typedef logic [3:0] bcd_t;
    localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/grm_timebase.sv
// Decade prescaler chain on the reference tick, plus a tap selector.
// Tap k pulses once every 10^k reference ticks. The selected tap is registered.
// Assumes ref_tick is a single-cycle pulse in the clk domain.
module grm_timebase
    import grm_pkg::*;
#(
    parameter int NUM_DECADES = 5,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] range_sel,
    output logic             sel_tick
);
    localparam int               NUM_DIV  = NUM_DECADES - 1;
    localparam logic [SEL_W-1:0] LAST_TAP = SEL_W'(NUM_DECADES - 1);

    logic [NUM_DECADES-1:0] tap;
    logic [NUM_DIV-1:0]     at_max;
    logic [SEL_W-1:0]       tap_idx;
    logic                   sel_tick_q;

    assign tap[0] = ref_tick;

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_decade
        bcd_t cnt_q;

        // Divide-by-ten stage: advances when every lower stage wraps
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (tap[k])
                cnt_q <= (cnt_q == BCD_MAX) ? '0 : cnt_q + 4'd1;
        end

        assign at_max[k]  = (cnt_q == BCD_MAX);
        assign tap[k+1]   = ref_tick & (&at_max[k:0]);
    end

    // Clamp out-of-range selections to the slowest tap
    always_comb begin
        tap_idx = (range_sel > LAST_TAP) ? LAST_TAP : range_sel;
    end

    // Register the chosen tap to cut the prescaler carry path
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_tick_q <= 1'b0;
        else
            sel_tick_q <= tap[tap_idx];
    end

    assign sel_tick = sel_tick_q;
endmodule

// File: rtl/grm_sequencer.sv
// Window sequencer made of two toggle stages.
// The sample stage halves the interval rate. The phase stage toggles as sample falls.
// Window open = sample high while phase high. The phase rise loads the result,
// and a one-cycle clear follows it. Assumes sel_tick is a single-cycle pulse.
module grm_sequencer (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_tick,
    output logic sample,
    output logic phase,
    output logic clr,
    output logic load,
    output logic win_open
);
    logic sample_q;
    logic phase_q;
    logic clr_q;
    logic phase_rise;

    assign phase_rise = sel_tick & sample_q & ~phase_q;

    // Sample toggle: one interval high, one interval low
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_q <= 1'b0;
        else if (sel_tick)
            sample_q <= ~sample_q;
    end

    // Phase toggle on each falling sample edge: measure or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (sel_tick && sample_q)
            phase_q <= ~phase_q;
    end

    // Clear pulse during the cycle after the phase rises
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_q <= 1'b0;
        else
            clr_q <= phase_rise;
    end

    assign sample   = sample_q;
    assign phase    = phase_q;
    assign clr      = clr_q;
    assign load     = phase_rise;
    assign win_open = sample_q & phase_q;
endmodule

// File: rtl/grm_bcd_digit.sv
// One BCD decade of the edge counter. It wraps 9 -> 0 and flags when it holds 9.
// Clear has priority over increment.
module grm_bcd_digit
    import grm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output bcd_t value,
    output logic at_max
);
    bcd_t val_q;

    // Digit register with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            val_q <= '0;
        else if (inc)
            val_q <= (val_q == BCD_MAX) ? '0 : val_q + 4'd1;
    end

    assign value  = val_q;
    assign at_max = (val_q == BCD_MAX);
endmodule

// File: rtl/gated_rate_meter.sv
// Top of the gated rate meter. It synchronises the unknown input and detects
// its rising edges. Edges are counted into cascaded BCD digits while the
// window is open. The count and overflow are held at each load point.
// Assumes ref_tick is synchronous to clk. sig_in may be asynchronous.
module gated_rate_meter
    import grm_pkg::*;
#(
    parameter int NUM_DECADES = 5,
    parameter int NUM_DIGITS  = 3,
    parameter int SEL_W       = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_tick,
    input  logic                    sig_in,
    input  logic [SEL_W-1:0]        range_sel,
    output logic [4*NUM_DIGITS-1:0] bcd_out,
    output logic                    overflow
);
    localparam int CNT_W = 4 * NUM_DIGITS;

    logic                  sel_tick;
    logic                  sample_q;
    logic                  x_q;
    logic                  clr_q;
    logic                  load_pulse;
    logic                  win_open;
    logic [2:0]            sync_q;
    logic                  sig_rise;
    logic                  inc_base;
    logic [NUM_DIGITS-1:0] dig_max;
    logic [CNT_W-1:0]      count_bcd;
    logic                  ovf_acc;
    logic [CNT_W-1:0]      disp_q;
    logic                  disp_ovf_q;

    grm_timebase #(
        .NUM_DECADES(NUM_DECADES),
        .SEL_W      (SEL_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .range_sel(range_sel),
        .sel_tick (sel_tick)
    );

    grm_sequencer u_sequencer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_tick(sel_tick),
        .sample  (sample_q),
        .phase   (x_q),
        .clr     (clr_q),
        .load    (load_pulse),
        .win_open(win_open)
    );

    // Two-stage synchroniser plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[1:0], sig_in};
    end

    assign sig_rise = sync_q[1] & ~sync_q[2];
    assign inc_base = sig_rise & win_open;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        logic inc_here;
        if (i == 0) begin : g_low
            assign inc_here = inc_base;
        end else begin : g_high
            assign inc_here = inc_base & (&dig_max[i-1:0]);
        end

        grm_bcd_digit u_digit (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_q),
            .inc   (inc_here),
            .value (count_bcd[4*i +: 4]),
            .at_max(dig_max[i])
        );
    end

    // Sticky overflow: set on carry out of the top digit, dropped by the clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_q)
            ovf_acc <= 1'b0;
        else if (inc_base && (&dig_max))
            ovf_acc <= 1'b1;
    end

    // Output hold: load the frozen count just before it is cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q     <= '0;
            disp_ovf_q <= 1'b0;
        end else if (load_pulse) begin
            disp_q     <= count_bcd;
            disp_ovf_q <= ovf_acc;
        end
    end

    assign bcd_out  = disp_q;
    assign overflow = disp_ovf_q;
endmodule

// File: rtl/grm_checker.sv
// Assertion checker for the gated rate meter, attached by bind.
// It watches the sequencer, the counter and the held outputs.
module grm_checker #(
    parameter int NUM_DIGITS = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_q,
    input logic                    x_q,
    input logic                    clr_q,
    input logic                    win_open,
    input logic                    load_pulse,
    input logic [4*NUM_DIGITS-1:0] count_bcd,
    input logic                    ovf_acc,
    input logic [4*NUM_DIGITS-1:0] disp_q,
    input logic                    disp_ovf_q
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> (count_bcd == '0) && !ovf_acc); // R5

    AST_SHUT_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !clr_q) |=> $stable(count_bcd) && $stable(ovf_acc)); // R4

    AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(disp_q) && $stable(disp_ovf_q)); // R7

    AST_PHASE_ON_SAMPLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_q) |-> (x_q != $past(x_q))); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_acc && !clr_q) |=> ovf_acc); // R6

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_range
        AST_DIGIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (count_bcd[4*i +: 4] <= 4'd9) && (disp_q[4*i +: 4] <= 4'd9)); // R8
    end
endmodule

bind gated_rate_meter grm_checker #(.NUM_DIGITS(NUM_DIGITS)) u_grm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_q  (sample_q),
    .x_q       (x_q),
    .clr_q     (clr_q),
    .win_open  (win_open),
    .load_pulse(load_pulse),
    .count_bcd (count_bcd),
    .ovf_acc   (ovf_acc),
    .disp_q    (disp_q),
    .disp_ovf_q(disp_ovf_q)
);

// File: tb/test_gated_rate_meter.sv
// Self-checking bench for gated_rate_meter. The reference tick is driven every
// cycle, so the interval is 10^range_sel clock cycles.
module test_gated_rate_meter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        sig_in = 1'b1;
    logic [2:0]  range_sel = 3'd3;
    logic [11:0] bcd_out;
    logic        overflow;

    int n_chk  = 0;
    int n_fail = 0;
    int half_p = 0;
    bit done   = 1'b0;

    // Vector table: range, half period of sig_in, expected reading, expected overflow
    localparam int NV = 6;
    localparam int VR [NV] = '{3, 3, 3, 2, 4, 3};
    localparam int VH [NV] = '{5, 1, 2, 1, 3, 50};
    localparam int VE [NV] = '{100, 500, 250, 50, 666, 10};
    localparam int VO [NV] = '{0, 0, 0, 0, 1, 0};

    gated_rate_meter i_gated_rate_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .sig_in   (sig_in),
        .range_sel(range_sel),
        .bcd_out  (bcd_out),
        .overflow (overflow)
    );

    always #5 clk = ~clk;

    // Unknown pulse source: toggles every half_p cycles, held high when half_p is 0
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (half_p == 0) begin
                sig_in <= 1'b1;
                ph = 0;
            end else begin
                ph++;
                if (ph >= half_p) begin
                    ph = 0;
                    sig_in <= ~sig_in;
                end
            end
        end
    end

    function automatic int reading();
        return int'(bcd_out[11:8]) * 100 + int'(bcd_out[7:4]) * 10 + int'(bcd_out[3:0]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        wait_cyc(5);
        // R1: reset state
        check(bcd_out == 12'h000, "R1 reset digits", int'(bcd_out), 0);
        check(overflow == 1'b0, "R1 reset overflow", int'(overflow), 0);
        rst_n = 1'b1;

        // Table walk: R2 interval scaling, R3 reading, R4 no doubling, R6 overflow, R8 digits
        for (int i = 0; i < NV; i++) begin
            int span;
            int got;
            range_sel = 3'(VR[i]);
            half_p    = VH[i];
            span = 1;
            for (int k = 0; k < VR[i]; k++) span = span * 10;
            wait_cyc(9 * span + 10);
            got = reading();
            check((got >= VE[i] - 1) && (got <= VE[i] + 1), "R3/R2/R4 reading", got, VE[i]);
            check(overflow == VO[i][0], "R6 overflow flag", int'(overflow), VO[i]);
            check((bcd_out[3:0] <= 4'd9) && (bcd_out[7:4] <= 4'd9) && (bcd_out[11:8] <= 4'd9),
                  "R8 digit range", int'(bcd_out), 0);
        end

        // R9: held-high input counts nothing
        range_sel = 3'd2;
        half_p    = 0;
        wait_cyc(910);
        check(bcd_out == 12'h000, "R9 level not counted", reading(), 0);

        // R5: display returns to zero exactly 4T after the first nonzero load
        begin
            int n = 0;
            half_p = 1;
            while (bcd_out == 12'h000 && n < 2000) begin
                wait_cyc(1);
                n++;
            end
            half_p = 0;
            n = 0;
            while (bcd_out != 12'h000 && n < 2000) begin
                wait_cyc(1);
                n++;
            end
            check(n == 400, "R5 sequence period", n, 400);
        end

        // R7: output changes at most once per 4T
        begin
            int changes = 0;
            logic [11:0] prev;
            half_p = 1;
            wait_cyc(910);
            prev = bcd_out;
            for (int c = 0; c < 399; c++) begin
                wait_cyc(1);
                if (bcd_out != prev) changes++;
                prev = bcd_out;
            end
            check(changes <= 1, "R7 held output", changes, 1);
            check((reading() >= 49) && (reading() <= 51), "R3 reading range 2", reading(), 50);
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        wait_cyc(3);
        check(bcd_out == 12'h000, "R1 mid-run reset digits", reading(), 0);
        check(overflow == 1'b0, "R1 mid-run reset overflow", int'(overflow), 0);
        rst_n = 1'b1;
        wait_cyc(2);

        done = 1'b1;
        finish_run();
    end
endmodule